// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block decides where the processor goes when an exception is taken and which saved-state registers change. The pipeline presents an event kind, the program counter of the faulting instruction, whether that instruction sat in a branch delay slot, the refill flag from the translation unit, the current Status and Cause control bits, the exception base register and the debug-mode flag. One clock later the block raises a single-cycle redirect carrying the new program counter. Alongside it come write strobes, with their values, for the exception PC, the error PC, the debug PC, the Cause code, BD and CE fields, and the EXL, ERL/BEV and debug-mode bits. The registers themselves live elsewhere. This block only says what to write.

General exceptions vector relative to either the boot area or the exception base. The offset depends on the event kind, the refill flag and EXL. Non-maskable interrupts and soft resets use the error PC and a fixed boot vector. Debug events use the debug PC and a fixed debug vector. An event kind the block does not support produces no redirect and no strobes. It sets a sticky error flag that only reset clears.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, redirect, every write strobe and `bad_kind` are low.
- R2: A general exception vectors to base + 0x180. The base is 0xBFC00200 when `sr_bev` is 1, or `ebase` with bits 9..0 cleared when `sr_bev` is 0.
- R3: A TLB load (kind 2) or TLB store (kind 3) with `tlb_refill` = 1 uses offset 0x000 only when `sr_exl` = 0. With `sr_exl` = 1, or with `tlb_refill` = 0, it uses 0x180.
- R4: An interrupt (kind 0) outside debug mode uses offset 0x200 when `cause_iv` = 1, and 0x180 otherwise.
- R5: On every redirect, `save_pc` is `pc`, or `pc` - 4 when `in_delay` = 1 (single-step excepted, see R9). For a general exception with `sr_exl` = 0, `epc_we`, `bd_we` and `exl_set` pulse, with `bd_val` = `in_delay`. With `sr_exl` = 1, none of them pulse.
- R6: For a general exception, `code_we` pulses and `code_val` equals the kind. The supported kinds are: interrupt 0, TLB modify 1, TLB load 2, TLB store 3, address error load 4, address error store 5, instruction bus error 6, data bus error 7, syscall 8, break 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, floating point 15.
- R7: Coprocessor unusable (kind 11) also pulses `ce_we`, with `ce_val` = `cop_num`. No other kind pulses `ce_we`.
- R8: Soft reset (kind 16) and NMI (kind 17) pulse `errepc_we` and `erl_bev_set`, and vector to 0xBFC00000. They do not pulse `code_we` or `epc_we`.
- R9: A debug event (kind 18), or an interrupt while `debug_mode` = 1, pulses `depc_wr` and `debug_enter`, and vectors to 0xBFC00480. In the interrupt case, `debug_int` also pulses. Single-step (kind 19) does the same but saves `pc` unadjusted.
- R10: `redirect` is high exactly in the cycle after a cycle with `exc_valid` = 1 and a supported kind. It is low otherwise. A redirect means the receiver forces kernel mode and clears its delay-slot state.
- R11: Kinds 14 and 20..31 raise no redirect and no strobe, and set `bad_kind`. `bad_kind` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | An exception is taken this cycle |
| exc_kind | input | 5 | Event kind (encoding in R6, R8, R9, R11) |
| pc | input | 32 | PC of the faulting instruction |
| in_delay | input | 1 | Faulting instruction is in a delay slot |
| tlb_refill | input | 1 | Translation miss had no matching entry |
| sr_bev | input | 1 | Current Status boot-vector bit |
| sr_exl | input | 1 | Current Status exception-level bit |
| cause_iv | input | 1 | Current Cause interrupt-vector bit |
| debug_mode | input | 1 | Processor currently in debug mode |
| ebase | input | 32 | Exception base register |
| cop_num | input | 2 | Coprocessor number for kind 11 |
| redirect | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | 32 | New program counter |
| save_pc | output | 32 | Value for whichever save register is written |
| epc_we | output | 1 | Write exception PC |
| errepc_we | output | 1 | Write error PC |
| depc_wr | output | 1 | Write debug PC |
| bd_we | output | 1 | Write Cause BD |
| bd_val | output | 1 | Cause BD value |
| code_we | output | 1 | Write Cause exception code |
| code_val | output | 5 | Cause exception code value |
| ce_we | output | 1 | Write Cause CE |
| ce_val | output | 2 | Cause CE value |
| exl_set | output | 1 | Set Status EXL |
| erl_bev_set | output | 1 | Set Status ERL and BEV |
| debug_enter | output | 1 | Enter debug mode |
| debug_int | output | 1 | Interrupt was converted to a debug interrupt |
| bad_kind | output | 1 | Sticky unsupported-kind flag |

## Verification
Two handling paths meet in one cycle in these cases:
- An interrupt arrives while `debug_mode` is high. The interrupt-vector path (IV offset, Cause code, EPC) and the debug path both apply. The bench sets `cause_iv` as well, so that a wrong priority would show as a 0x200-offset vector or a `code_we` pulse. It expects only the debug strobes, 0xBFC00480, and the delay-adjusted PC.
- A refill-flagged TLB miss is taken while EXL is already set. The refill offset and the nested-exception suppression of EPC/BD/EXL both apply. The bench expects offset 0x180, a Cause code write, and no EPC write.

An unsupported kind is followed directly by a valid one. This shows the sticky flag does not block later exceptions.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

  localparam int KIND_W = 5;

  // kind encodings that drive behaviour
  localparam logic [KIND_W-1:0] K_INT    = 5'd0;
  localparam logic [KIND_W-1:0] K_TLBLD  = 5'd2;
  localparam logic [KIND_W-1:0] K_TLBST  = 5'd3;
  localparam logic [KIND_W-1:0] K_COPU   = 5'd11;
  localparam logic [KIND_W-1:0] K_SRST   = 5'd16;
  localparam logic [KIND_W-1:0] K_NMI    = 5'd17;
  localparam logic [KIND_W-1:0] K_DBG    = 5'd18;
  localparam logic [KIND_W-1:0] K_STEP   = 5'd19;

  typedef enum logic [2:0] {
    CL_BAD,   // unsupported kind
    CL_GEN,   // general exception through Cause/EPC
    CL_ERR,   // NMI or soft reset
    CL_DBG,   // debug event, delay-adjusted
    CL_STEP   // single-step, PC unadjusted
  } exc_class_e;

  localparam logic [31:0] VEC_BOOT_GEN = 32'hBFC0_0200;
  localparam logic [31:0] VEC_ERR      = 32'hBFC0_0000;
  localparam logic [31:0] VEC_DBG      = 32'hBFC0_0480;

  localparam logic [11:0] OFS_GEN   = 12'h180;
  localparam logic [11:0] OFS_REFIL = 12'h000;
  localparam logic [11:0] OFS_IV    = 12'h200;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_vec_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic              in_dbg,
  output exc_class_e        cls,
  output logic              dbg_from_int
);
  always_comb begin
    dbg_from_int = 1'b0;
    unique case (kind)
      5'd0: begin
        if (in_dbg) begin
          cls          = CL_DBG;
          dbg_from_int = 1'b1;
        end else begin
          cls = CL_GEN;
        end
      end
      5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8,
      5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd15: cls = CL_GEN;
      K_SRST, K_NMI: cls = CL_ERR;
      K_DBG:         cls = CL_DBG;
      K_STEP:        cls = CL_STEP;
      default:       cls = CL_BAD;
    endcase
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_vec_pkg::*;
#(
  parameter int AW      = 32,
  parameter int BASE_LO = 10
) (
  input  exc_class_e        cls,
  input  logic [KIND_W-1:0] kind,
  input  logic              bev,
  input  logic              exl,
  input  logic              iv,
  input  logic              refill,
  input  logic [AW-1:0]     ebase,
  output logic [AW-1:0]     target
);
  localparam logic [AW-1:0] LO_MASK = AW'((64'd1 << BASE_LO) - 64'd1);

  logic [AW-1:0] gen_base;
  logic [11:0]   offset;
  logic          is_tlb;

  assign is_tlb   = (kind == K_TLBLD) || (kind == K_TLBST);
  assign gen_base = bev ? AW'(VEC_BOOT_GEN) : (ebase & ~LO_MASK);

  always_comb begin
    if (kind == K_INT && iv)              offset = OFS_IV;
    else if (is_tlb && refill && !exl)    offset = OFS_REFIL;
    else                                  offset = OFS_GEN;
  end

  always_comb begin
    unique case (cls)
      CL_GEN:           target = gen_base + AW'(offset);
      CL_ERR:           target = AW'(VEC_ERR);
      CL_DBG, CL_STEP:  target = AW'(VEC_DBG);
      default:          target = '0;
    endcase
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_vec_pkg::*;
#(
  parameter int AW      = 32,
  parameter int INSN_B  = 4,
  parameter int BASE_LO = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_valid,
  input  logic [4:0]        exc_kind,
  input  logic [AW-1:0]     pc,
  input  logic              in_delay,
  input  logic              tlb_refill,
  input  logic              sr_bev,
  input  logic              sr_exl,
  input  logic              cause_iv,
  input  logic              debug_mode,
  input  logic [AW-1:0]     ebase,
  input  logic [1:0]        cop_num,
  output logic              redirect,
  output logic [AW-1:0]     redirect_pc,
  output logic [AW-1:0]     save_pc,
  output logic              epc_we,
  output logic              errepc_we,
  output logic              depc_wr,
  output logic              bd_we,
  output logic              bd_val,
  output logic              code_we,
  output logic [4:0]        code_val,
  output logic              ce_we,
  output logic [1:0]        ce_val,
  output logic              exl_set,
  output logic              erl_bev_set,
  output logic              debug_enter,
  output logic              debug_int,
  output logic              bad_kind
);
  exc_class_e    cls;
  logic          dbg_from_int;
  logic [AW-1:0] tgt;
  logic [AW-1:0] adj_pc;
  logic          gen, first;

  exc_classify u_cls (
    .kind        (exc_kind),
    .in_dbg      (debug_mode),
    .cls         (cls),
    .dbg_from_int(dbg_from_int)
  );

  exc_target #(.AW(AW), .BASE_LO(BASE_LO)) u_tgt (
    .cls   (cls),
    .kind  (exc_kind),
    .bev   (sr_bev),
    .exl   (sr_exl),
    .iv    (cause_iv),
    .refill(tlb_refill),
    .ebase (ebase),
    .target(tgt)
  );

  assign adj_pc = (in_delay && cls != CL_STEP) ? pc - AW'(INSN_B) : pc;
  assign gen    = exc_valid && cls == CL_GEN;
  assign first  = gen && !sr_exl;

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect    <= 1'b0;
      redirect_pc <= '0;
      save_pc     <= '0;
      epc_we      <= 1'b0;
      errepc_we   <= 1'b0;
      depc_wr     <= 1'b0;
      bd_we       <= 1'b0;
      bd_val      <= 1'b0;
      code_we     <= 1'b0;
      code_val    <= '0;
      ce_we       <= 1'b0;
      ce_val      <= '0;
      exl_set     <= 1'b0;
      erl_bev_set <= 1'b0;
      debug_enter <= 1'b0;
      debug_int   <= 1'b0;
      bad_kind    <= 1'b0;
    end else begin
      redirect    <= exc_valid && cls != CL_BAD;
      redirect_pc <= tgt;
      save_pc     <= adj_pc;
      epc_we      <= first;
      bd_we       <= first;
      bd_val      <= in_delay;
      exl_set     <= first;
      code_we     <= gen;
      code_val    <= exc_kind;
      ce_we       <= gen && exc_kind == K_COPU;
      ce_val      <= cop_num;
      errepc_we   <= exc_valid && cls == CL_ERR;
      erl_bev_set <= exc_valid && cls == CL_ERR;
      depc_wr     <= exc_valid && (cls == CL_DBG || cls == CL_STEP);
      debug_enter <= exc_valid && (cls == CL_DBG || cls == CL_STEP);
      debug_int   <= exc_valid && dbg_from_int;
      if (exc_valid && cls == CL_BAD) bad_kind <= 1'b1;
    end
  end

  // R10: a redirect only follows a taken exception
  p_redirect_cause_r10: assert property (@(posedge clk) disable iff (rst)
    redirect |-> $past(exc_valid));
  // R5: EPC is written only when EXL was clear
  p_epc_exl_clear_r5: assert property (@(posedge clk) disable iff (rst)
    epc_we |-> !$past(sr_exl));
  // R5: BD value follows the delay-slot input
  p_bd_follows_r5: assert property (@(posedge clk) disable iff (rst)
    bd_we |-> bd_val == $past(in_delay));
  // R11: the error flag is sticky
  p_bad_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    bad_kind |=> bad_kind);
  // R11: no strobe without a redirect
  p_no_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    (epc_we || errepc_we || depc_wr || code_we || ce_we) |-> redirect);
  // R8/R9: at most one save register is written
  p_one_save_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({epc_we, errepc_we, depc_wr}));
  // R7: CE is written only with a Cause code write of kind 11
  p_ce_copu_r7: assert property (@(posedge clk) disable iff (rst)
    ce_we |-> (code_we && code_val == 5'd11));
endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_kind = '0;
  logic [31:0] pc = '0;
  logic        in_delay = 1'b0, tlb_refill = 1'b0, sr_bev = 1'b0, sr_exl = 1'b0;
  logic        cause_iv = 1'b0, debug_mode = 1'b0;
  logic [31:0] ebase = 32'h8000_1234;
  logic [1:0]  cop_num = 2'd2;
  logic        redirect, epc_we, errepc_we, depc_wr, bd_we, bd_val, code_we, ce_we;
  logic        exl_set, erl_bev_set, debug_enter, debug_int, bad_kind;
  logic [31:0] redirect_pc, save_pc;
  logic [4:0]  code_val;
  logic [1:0]  ce_val;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  exc_entry_ctrl uut (.*);

  typedef struct packed {
    logic [4:0]  kind;
    logic        dly, rf, bev, exl, iv, dbg;
    logic [31:0] pc;
    logic [31:0] exp_pc;
    logic [31:0] exp_save;
    logic [3:0]  exp_we;   // epc, errepc, depc, code
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{5'd8,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h400,  32'h8000_1180, 32'h400,  4'b1001},
    '{5'd8,  1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 32'h400,  32'hBFC0_0380, 32'h400,  4'b1001},
    '{5'd2,  1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h800,  32'h8000_1000, 32'h800,  4'b1001},
    '{5'd3,  1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 32'h804,  32'h8000_1180, 32'h804,  4'b0001},
    '{5'd0,  1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 32'h900,  32'h8000_1200, 32'h900,  4'b1001},
    '{5'd0,  1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 32'h900,  32'hBFC0_0400, 32'h900,  4'b1001},
    '{5'd9,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h1000, 32'h8000_1180, 32'hFFC,  4'b1001},
    '{5'd17, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h2000, 32'hBFC0_0000, 32'h1FFC, 4'b0100},
    '{5'd16, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h2100, 32'hBFC0_0000, 32'h2100, 4'b0100},
    '{5'd18, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h3000, 32'hBFC0_0480, 32'h3000, 4'b0010},
    '{5'd0,  1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 32'h3004, 32'hBFC0_0480, 32'h3000, 4'b0010},
    '{5'd19, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 32'h5000, 32'hBFC0_0480, 32'h5000, 4'b0010},
    '{5'd2,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h600,  32'h8000_1180, 32'h600,  4'b1001},
    '{5'd12, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 32'h700,  32'hBFC0_0380, 32'h700,  4'b0001},
    '{5'd11, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h704,  32'h8000_1180, 32'h704,  4'b1001}
  };

  function automatic string tag_of(input logic [4:0] k, input logic dbg, input logic rf);
    if (k == 5'd16 || k == 5'd17) return "R8";
    if (k >= 5'd18 || (k == 5'd0 && dbg)) return "R9";
    if (k == 5'd0) return "R4";
    if (rf) return "R3";
    return "R2";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic fire(input logic [4:0] k, input logic [31:0] p, input logic d);
    @(negedge clk);
    exc_kind = k; pc = p; in_delay = d; exc_valid = 1'b1;
    @(negedge clk);
    exc_valid = 1'b0;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!redirect && !epc_we && !errepc_we && !depc_wr && !code_we && !bad_kind,
        "R1", "reset outputs", {redirect, epc_we, errepc_we, depc_wr, code_we, bad_kind}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tlb_refill = VECS[i].rf; sr_bev = VECS[i].bev; sr_exl = VECS[i].exl;
      cause_iv = VECS[i].iv; debug_mode = VECS[i].dbg;
      exc_kind = VECS[i].kind; pc = VECS[i].pc; in_delay = VECS[i].dly;
      exc_valid = 1'b1;
      @(negedge clk);
      exc_valid = 1'b0;
      begin
        string t;
        t = tag_of(VECS[i].kind, VECS[i].dbg, VECS[i].rf);
        chk(redirect === 1'b1, "R10", "redirect", redirect, 1);
        chk(redirect_pc === VECS[i].exp_pc, t, "vector", redirect_pc, VECS[i].exp_pc);
        chk(save_pc === VECS[i].exp_save, "R5", "save_pc", save_pc, VECS[i].exp_save);
        chk({epc_we, errepc_we, depc_wr, code_we} === VECS[i].exp_we, t, "strobes",
            {epc_we, errepc_we, depc_wr, code_we}, VECS[i].exp_we);
        chk(bd_we === VECS[i].exp_we[3] && exl_set === VECS[i].exp_we[3], "R5",
            "bd/exl strobes", {bd_we, exl_set}, {2{VECS[i].exp_we[3]}});
        if (bd_we) chk(bd_val === VECS[i].dly, "R5", "bd_val", bd_val, VECS[i].dly);
        if (VECS[i].exp_we[0])
          chk(code_val === VECS[i].kind, "R6", "code", code_val, VECS[i].kind);
        chk(erl_bev_set === VECS[i].exp_we[2], "R8", "erl_bev_set", erl_bev_set, VECS[i].exp_we[2]);
        chk(debug_enter === VECS[i].exp_we[1], "R9", "debug_enter", debug_enter, VECS[i].exp_we[1]);
        chk(debug_int === (VECS[i].kind == 5'd0 && VECS[i].dbg), "R9", "debug_int",
            debug_int, (VECS[i].kind == 5'd0 && VECS[i].dbg));
        chk(ce_we === (VECS[i].kind == 5'd11), "R7", "ce_we", ce_we, (VECS[i].kind == 5'd11));
        if (ce_we) chk(ce_val === 2'd2, "R7", "ce_val", ce_val, 2);
      end
      @(negedge clk);
      chk(redirect === 1'b0, "R10", "pulse width", redirect, 0);
    end

    // R10/R11: unsupported kind
    sr_bev = 1'b0; sr_exl = 1'b0; debug_mode = 1'b0; cause_iv = 1'b0; tlb_refill = 1'b0;
    fire(5'd14, 32'hA00, 1'b0);
    chk(!redirect && !epc_we && !code_we && !errepc_we && !depc_wr, "R11",
        "no strobes kind 14", {redirect, epc_we, code_we, errepc_we, depc_wr}, 0);
    chk(bad_kind === 1'b1, "R11", "bad flag set", bad_kind, 1);
    // valid exception right after: still works, flag stays
    fire(5'd10, 32'hB00, 1'b0);
    chk(redirect === 1'b1 && redirect_pc === 32'h8000_1180, "R2",
        "after bad kind", redirect_pc, 32'h8000_1180);
    chk(bad_kind === 1'b1, "R11", "bad flag sticky", bad_kind, 1);
    fire(5'd25, 32'hC00, 1'b0);
    chk(redirect === 1'b0, "R11", "kind 25 ignored", redirect, 0);

    // R10: back-to-back exceptions give two pulses
    @(negedge clk);
    exc_kind = 5'd4; pc = 32'hD00; exc_valid = 1'b1;
    @(negedge clk);
    chk(redirect === 1'b1 && code_val === 5'd4, "R10", "first of pair", code_val, 4);
    exc_kind = 5'd5; pc = 32'hD04;
    @(negedge clk);
    exc_valid = 1'b0;
    chk(redirect === 1'b1 && code_val === 5'd5 && save_pc === 32'hD04, "R10",
        "second of pair", save_pc, 32'hD04);

    // R1: reset clears the sticky flag
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(bad_kind === 1'b0 && redirect === 1'b0, "R1", "reset clears flag", bad_kind, 0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule